// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Filter

This block watches the synchronised receive level of a LIN bus while the transceiver sits in one of its low-power modes. It recognises a remote wake-up only when it sees the whole pattern: the bus falls from recessive to dominant, stays dominant for at least the qualifying time, and then returns to recessive. Glitches, short dominant phases and a bus that is already dominant when low power begins do not wake the node.

When a complete pattern is seen, the block raises a one-cycle wake request, which the mode controller uses to move to fail-safe mode. At the same moment it latches a wake indication that pulls both the host's receive pin and its transmit pin low, so the host is interrupted. The indication stays latched until the controller enters normal mode. Outside the low-power modes the detector is idle and its timer is held at zero.

The qualifying time is given in clock cycles by a parameter. Its default is 90 µs at a 250 MHz clock.

Top module: `lin_wake_filter`

## Requirements
- R1: After reset, wake_pulse, wake_ind_rxd and wake_ind_txd are all 0.
- R2: Timing starts only on a transition of bus_rx from 1 (recessive) to 0 (dominant) sampled while lp_mode is 1. A bus that is already dominant when lp_mode rises does not start timing and produces no wake, even after a long dominant phase and a return to recessive.
- R3: If at least DOM_CYCLES consecutive samples of bus_rx are 0 and the next sample is 1, wake_pulse is 1 for exactly one cycle. It is visible in the cycle after the clock edge that samples the first 1.
- R4: A dominant phase of fewer than DOM_CYCLES samples that then returns to recessive produces no wake and clears the timer. Two short phases split by one recessive sample never add up to a wake.
- R5: wake_pulse stays 0 for as long as the bus stays dominant, including past DOM_CYCLES samples. The request is issued only on the return to recessive.
- R6: wake_ind_rxd and wake_ind_txd both become 1 in the same cycle as wake_pulse. They rise at no other time, and they stay at 1 while normal_mode is 0.
- R7: A sample of normal_mode at 1 sets both indication outputs to 0 in the next cycle. It takes priority over a wake that completes on the same edge.
- R8: A sample of lp_mode at 0 aborts any pattern in progress. No wake follows from that pattern, even if lp_mode returns to 1 while the bus is still dominant and the bus then goes recessive.
- R9: wake_pulse is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_mode | input | 1 | 1 while the controller is in silent or sleep mode |
| normal_mode | input | 1 | 1 while the controller is in normal mode; releases the indication |
| bus_rx | input | 1 | Synchronised bus level, 1 recessive, 0 dominant |
| wake_pulse | output | 1 | One-cycle remote wake request to the mode controller |
| wake_ind_rxd | output | 1 | 1 holds the host receive pin low as wake indication |
| wake_ind_txd | output | 1 | 1 holds the host transmit pin low as wake indication |

## Verification
The assertions check the following on every cycle: the request is a single cycle, it follows a dominant-then-recessive pair of samples, and it only happens in low-power mode. They also check that the indication rises only together with a request and is released one cycle after normal mode is seen. The assertions cannot check the length of the dominant phase, because that depends on the timing threshold. The bench scenarios cover that part: the exact threshold and one sample below it, two short phases that must not add up, a bus that is already dominant when low power begins, an abort partway through a pattern, and random dominant lengths on both sides of the threshold.

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int DOM_CYCLES = 22500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_mode,
  input  logic normal_mode,
  input  logic bus_rx,
  output logic wake_pulse,
  output logic wake_ind_rxd,
  output logic wake_ind_txd
);

  localparam int CW = $clog2(DOM_CYCLES + 1);
  localparam logic [CW-1:0] CLIM = CW'(DOM_CYCLES);

  typedef enum logic [1:0] {S_IDLE, S_TIME, S_QUAL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          bus_q;
  logic          hold;

  wire fall  = bus_q & ~bus_rx;
  wire fires = lp_mode && (st == S_QUAL) && bus_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bus_q      <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      bus_q      <= bus_rx;
      wake_pulse <= 1'b0;
      if (!lp_mode) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE:
            if (fall) begin
              cnt <= CW'(1);
              st  <= (CLIM == CW'(1)) ? S_QUAL : S_TIME;
            end
          S_TIME:
            if (bus_rx) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
              if ((cnt + 1'b1) == CLIM) st <= S_QUAL;
            end
          S_QUAL:
            if (bus_rx) begin
              st         <= S_IDLE;
              cnt        <= '0;
              wake_pulse <= 1'b1;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold <= 1'b0;
    else if (normal_mode) hold <= 1'b0;
    else if (fires)       hold <= 1'b1;
  end

  assign wake_ind_rxd = hold;
  assign wake_ind_txd = hold;

endmodule

// File: rtl/lin_wake_filter_chk.sv
module lin_wake_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic lp_mode,
  input logic normal_mode,
  input logic bus_rx,
  input logic wake_pulse,
  input logic wake_ind_rxd,
  input logic wake_ind_txd
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R9

  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ($past(bus_rx) && !$past(bus_rx, 2))); // R3

  AST_WAKE_IN_LP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(lp_mode)); // R8

  AST_IND_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake_ind_rxd) || $rose(wake_ind_txd)) |-> wake_pulse); // R6

  AST_IND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    normal_mode |=> (!wake_ind_rxd && !wake_ind_txd)); // R7

  AST_IND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_ind_rxd && !normal_mode) |=> wake_ind_rxd); // R6

endmodule

bind lin_wake_filter lin_wake_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .normal_mode(normal_mode),
  .bus_rx(bus_rx), .wake_pulse(wake_pulse),
  .wake_ind_rxd(wake_ind_rxd), .wake_ind_txd(wake_ind_txd)
);

// File: tb/lin_wake_filter_tb.sv
`timescale 1ns/1ps
module lin_wake_filter_tb;

  localparam int DOM = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_mode = 1'b0;
  logic normal_mode = 1'b1;
  logic bus_rx = 1'b1;
  logic wake_pulse, wake_ind_rxd, wake_ind_txd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_wake_filter #(.DOM_CYCLES(DOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .normal_mode(normal_mode),
    .bus_rx(bus_rx), .wake_pulse(wake_pulse),
    .wake_ind_rxd(wake_ind_rxd), .wake_ind_txd(wake_ind_txd)
  );

  function automatic int exp_wake(int n);
    return (n >= DOM) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(output bit w);
    @(posedge clk); #1;
    w = wake_pulse;
  endtask

  task automatic low_phase(int n, inout int pulses);
    bit w;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_rx = 1'b0;
      step(w);
      pulses += int'(w);
    end
  endtask

  task automatic rise(output int first, inout int pulses);
    bit w;
    @(negedge clk); bus_rx = 1'b1;
    step(w);
    first = int'(w);
    pulses += int'(w);
    for (int i = 0; i < 3; i++) begin
      step(w);
      pulses += int'(w);
    end
  endtask

  task automatic pattern(int n, output int first, output int pulses);
    int during = 0;
    pulses = 0;
    low_phase(n, during);
    pulses = during;
    rise(first, pulses);
  endtask

  task automatic release_ind();
    @(negedge clk); normal_mode = 1'b1; lp_mode = 1'b0;
    @(negedge clk); normal_mode = 1'b0; lp_mode = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int first, pulses, n, gap;
    bit w;
    void'($urandom(32'h5eed_1a2b));

    repeat (3) @(posedge clk);
    #1;
    check(wake_pulse == 1'b0, "R1 wake_pulse", wake_pulse, 0);
    check(wake_ind_rxd == 1'b0 && wake_ind_txd == 1'b0, "R1 indication",
          wake_ind_rxd + wake_ind_txd, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); normal_mode = 1'b0; lp_mode = 1'b1;
    repeat (2) @(posedge clk);

    // R3: exactly DOM dominant samples
    pattern(DOM, first, pulses);
    check(first == 1, "R3 wake at rise, exact threshold", first, 1);
    check(pulses == 1, "R9 single pulse", pulses, 1);
    check(wake_ind_rxd && wake_ind_txd, "R6 indication set", wake_ind_rxd + wake_ind_txd, 2);
    repeat (6) step(w);
    check(wake_ind_rxd && wake_ind_txd, "R6 indication held", wake_ind_rxd + wake_ind_txd, 2);
    release_ind();
    check(!wake_ind_rxd && !wake_ind_txd, "R7 indication released", wake_ind_rxd + wake_ind_txd, 0);

    // R4: one sample short
    pattern(DOM - 1, first, pulses);
    check(pulses == 0, "R4 short phase", pulses, 0);

    // R4: two short phases split by one recessive sample
    pulses = 0;
    low_phase(DOM - 1, pulses);
    @(negedge clk); bus_rx = 1'b1;
    step(w); pulses += int'(w);
    low_phase(DOM - 1, pulses);
    rise(first, pulses);
    check(pulses == 0, "R4 timer cleared between phases", pulses, 0);
    check(!wake_ind_rxd, "R4 no indication", wake_ind_rxd, 0);

    // R5: long dominant, no request until rise
    begin
      int during = 0;
      low_phase(DOM + 10, during);
      check(during == 0, "R5 no wake while dominant", during, 0);
      pulses = during;
      rise(first, pulses);
      check(first == 1 && pulses == 1, "R5 wake on rise", first + pulses, 2);
    end
    release_ind();

    // R2: bus already dominant when low power begins
    @(negedge clk); lp_mode = 1'b0; bus_rx = 1'b0;
    repeat (3) step(w);
    @(negedge clk); lp_mode = 1'b1;
    pulses = 0;
    low_phase(DOM + 4, pulses);
    rise(first, pulses);
    check(pulses == 0, "R2 no arm without falling edge", pulses, 0);

    // R2: falling edge outside low power does not arm
    @(negedge clk); lp_mode = 1'b0; bus_rx = 1'b0;
    step(w);
    @(negedge clk); lp_mode = 1'b1;
    pulses = 0;
    low_phase(DOM + 2, pulses);
    rise(first, pulses);
    check(pulses == 0, "R2 edge outside low power", pulses, 0);

    // R8: abort partway through
    pulses = 0;
    low_phase(DOM + 2, pulses);
    @(negedge clk); lp_mode = 1'b0;
    step(w); pulses += int'(w);
    @(negedge clk); lp_mode = 1'b1;
    low_phase(3, pulses);
    rise(first, pulses);
    check(pulses == 0, "R8 abort on leaving low power", pulses, 0);
    check(!wake_ind_rxd && !wake_ind_txd, "R8 no indication", wake_ind_rxd + wake_ind_txd, 0);

    // R7: release has priority over a simultaneous wake
    @(negedge clk); normal_mode = 1'b1;
    pattern(DOM, first, pulses);
    check(first == 1, "R7 wake still requested", first, 1);
    check(!wake_ind_rxd && !wake_ind_txd, "R7 release priority", wake_ind_rxd + wake_ind_txd, 0);
    @(negedge clk); normal_mode = 1'b0;

    // Random dominant lengths around the threshold
    for (int k = 0; k < 40; k++) begin
      n = 1 + int'($urandom_range(2 * DOM - 1));
      gap = int'($urandom_range(4));
      repeat (gap) step(w);
      pattern(n, first, pulses);
      check(first == exp_wake(n) && pulses == exp_wake(n), "R3 random length",
            first * 10 + pulses, exp_wake(n) * 11);
      check(wake_ind_rxd == exp_wake(n)[0] && wake_ind_txd == exp_wake(n)[0],
            "R6 random indication", wake_ind_rxd + wake_ind_txd, 2 * exp_wake(n));
      if (wake_ind_rxd) begin
        release_ind();
        check(!wake_ind_rxd, "R7 random release", wake_ind_rxd, 0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule